// File: doc/BRIEF.md
# Escalating Watchdog Timer

This block guards one processor core against lockup. Software programs a reload length and an escalation mode in a single configuration write. The block then counts the period down, and software must poke it before the period runs out. If it is not poked, each expired period moves the block one stage further:
- first an interrupt request,
- then a non-maskable interrupt,
- and last a one-cycle request for a chip-wide soft reset.

A free-running prescaler divides the clock by `2**PRESC_LOG2`. The decrementer is `LEN_W + FRAC_W` bits wide. The programmed length fills only its upper `LEN_W` bits, and the low `FRAC_W` bits load as zero. With the defaults (16, 8, 8), one period can reach about 2^32 clocks. The escalation mode sets the highest stage the block may reach, and mode 0 turns the block off. The current stage is always visible on a 2-bit state output. Bit 1 of that output tells a watchdog NMI apart from other NMI sources.

Top module: `multi_stage_watchdog`

## Requirements
- R1: After reset the state output is 0, `irq`, `nmi` and `soft_reset` are low, and the mode is 0 (off).
- R2: The decrementer loads `{length, FRAC_W zeros}` and steps down once every `2**PRESC_LOG2` clocks. A period is counted from the edge that takes a configuration write or poke. It expires `(length*2**FRAC_W + 1) * 2**PRESC_LOG2` clock edges later, and every later period has the same length.
- R3: Each expiry moves the stage up by exactly one step: 0 to 1, 1 to 2, 2 to 3. The stage never skips a step. It only ever moves up by one or returns to 0.
- R4: The state output encodes the stages as 0 idle, 1 interrupt, 2 NMI, 3 reset requested. `irq` is high whenever the state is nonzero. `nmi` equals state bit 1, so it is high in states 2 and 3.
- R5: A poke with no configuration write in the same cycle returns the state to 0 on the next edge and drops `irq` and `nmi`. It also restarts the period from the stored length.
- R6: Mode 0 turns the watchdog off. The state stays 0 and all three stage outputs stay low for as long as the mode is 0.
- R7: The mode is the highest stage the block can reach: mode 1 stops at state 1, mode 2 at state 2, mode 3 at state 3. Once there, the block stays in that stage with the decrementer held at zero.
- R8: `soft_reset` is high for exactly one cycle, the cycle in which the state first becomes 3. The state then stays 3 until a poke or a configuration write.
- R9: A configuration write stores the new length and mode, restarts the period from the new length and returns the state to 0. If a poke arrives in the same cycle, the new length is used.
- R10: A length of 0 with a nonzero mode makes every period expire on its first prescale tick, that is `2**PRESC_LOG2` edges after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Reload length, upper bits of the decrementer |
| cfg_mode | input | 2 | Escalation mode: 0 off, 1 to 3 highest stage |
| poke | input | 1 | Service strobe that restarts the period |
| irq | output | 1 | Interrupt request, high in states 1 to 3 |
| nmi | output | 1 | Non-maskable interrupt, high in states 2 and 3 |
| soft_reset | output | 1 | One-cycle soft-reset request |
| wdog_state | output | 2 | Current escalation stage |

## Verification
The assertions assume that `cfg_we` and `poke` are single-cycle strobes. They also assume that `cfg_mode` and `cfg_len` only matter in the cycle of a write, so the stored values can change only at a configuration edge. The stimulus drives every strobe for exactly one cycle, always just after a clock edge. It then waits whole periods with no other input activity, so each expected stage change falls on a cycle the bench has computed. The bench shortens the prescaler and the fraction bits to 2 bits each, which keeps a three-stage escalation within a few hundred cycles. The formulas in the requirements are unchanged by that choice.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_IRQ  = 2'd1,
      ST_NMI  = 2'd2,
      ST_RST  = 2'd3
   } wdg_stage_e;

   localparam int MODE_W = 2;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int PRESC_LOG2 = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic tick
);
   generate
      if (PRESC_LOG2 < 0) begin : g_bad
         $error("PRESC_LOG2 must not be negative");
      end
      if (PRESC_LOG2 == 0) begin : g_direct
         logic unused_pins;
         assign unused_pins = clear ^ clk ^ rst_n;
         assign tick = run;
      end else begin : g_div
         localparam logic [PRESC_LOG2-1:0] LAST = '1;
         logic [PRESC_LOG2-1:0] div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     div_q <= '0;
            else if (clear) div_q <= '0;
            else if (run)   div_q <= div_q + 1'b1;
         end

         assign tick = run && (div_q == LAST);

         // R2: the divider stands still while the watchdog is off
         a_r2_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear && !run) |=> $stable(div_q));
      end
   endgenerate
endmodule

// File: rtl/wdg_downcount.sv
module wdg_downcount #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;
   logic             at_zero;

   assign at_zero = (cnt_q == '0);
   assign expire  = tick && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load)             cnt_q <= load_val;
      else if (tick && !at_zero) cnt_q <= cnt_q - 1'b1;
   end

   // R2: the count moves only on a prescale tick or a load
   a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !tick) |=> $stable(cnt_q));
   // R7: a count held at zero stays at zero until it is reloaded
   a_r7_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && at_zero) |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_stage_fsm.sv
module wdg_stage_fsm
   import wdg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              expire,
   input  logic [MODE_W-1:0] mode,
   output wdg_stage_e        stage,
   output logic              advanced,
   output logic              rst_pulse
);
   wdg_stage_e stage_q;
   logic       can_adv;
   logic       pulse_q;

   assign can_adv  = (MODE_W'(stage_q) < mode);
   assign advanced = expire && can_adv && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= ST_IDLE;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= advanced && (stage_q == ST_NMI);
         if (clear)         stage_q <= ST_IDLE;
         else if (advanced) stage_q <= wdg_stage_e'(stage_q + 2'd1);
      end
   end

   assign stage     = stage_q;
   assign rst_pulse = pulse_q;

   // R3: the stage either rises by one or returns to idle
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stage_q) |-> (stage_q == ST_IDLE) ||
                            (stage_q == wdg_stage_e'($past(stage_q) + 2'd1)));
   // R7: the stage never goes past the programmed mode
   a_r7_mode_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !$rose(clear)) |=> (MODE_W'(stage_q) <= mode) || (stage_q == ST_IDLE));
   // R8: the reset request lasts one cycle
   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
endmodule

// File: rtl/multi_stage_watchdog.sv
module multi_stage_watchdog
   import wdg_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int FRAC_W     = 8,
   parameter int PRESC_LOG2 = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic [1:0]       cfg_mode,
   input  logic             poke,
   output logic             irq,
   output logic             nmi,
   output logic             soft_reset,
   output logic [1:0]       wdog_state
);
   localparam int CNT_W = LEN_W + FRAC_W;

   generate
      if (LEN_W < 1)  begin : g_chk_len  $error("LEN_W must be at least 1"); end
      if (FRAC_W < 0) begin : g_chk_frac $error("FRAC_W must not be negative"); end
   endgenerate

   logic [LEN_W-1:0]  len_q;
   logic [MODE_W-1:0] mode_q;
   logic              enabled;
   logic              restart;
   logic              tick;
   logic              expire;
   logic              advanced;
   logic              reload;
   logic [LEN_W-1:0]  len_sel;
   logic [CNT_W-1:0]  load_val;
   wdg_stage_e        stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         mode_q <= '0;
      end else if (cfg_we) begin
         len_q  <= cfg_len;
         mode_q <= cfg_mode;
      end
   end

   assign enabled = (mode_q != '0);
   assign restart = cfg_we || poke;
   assign len_sel = cfg_we ? cfg_len : len_q;
   assign reload  = restart || advanced;

   generate
      if (FRAC_W == 0) begin : g_nofrac
         assign load_val = len_sel;
      end else begin : g_frac
         assign load_val = {len_sel, {FRAC_W{1'b0}}};
      end
   endgenerate

   wdg_prescaler #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart),
      .run   (enabled),
      .tick  (tick)
   );

   wdg_downcount #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (reload),
      .load_val (load_val),
      .tick     (tick && !restart),
      .expire   (expire)
   );

   wdg_stage_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (restart),
      .expire    (expire),
      .mode      (mode_q),
      .stage     (stage),
      .advanced  (advanced),
      .rst_pulse (soft_reset)
   );

   assign irq        = (stage != ST_IDLE);
   assign nmi        = stage[1];
   assign wdog_state = stage;

   // R5: a lone poke returns the block to idle on the next edge
   a_r5_poke_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (poke && !cfg_we) |=> (wdog_state == 2'd0) && !irq && !nmi);
   // R6: nothing is raised while the watchdog is off
   a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == '0) |-> (!irq && !nmi && !soft_reset && wdog_state == 2'd0));
   // R9: a configuration write restarts at idle
   a_r9_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (wdog_state == 2'd0));
   // R8: the reset request coincides with the reset-requested stage
   a_r8_pulse_stage: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |-> (wdog_state == 2'd3) && $past(wdog_state) == 2'd2);
endmodule

// File: tb/multi_stage_watchdog_test.sv
module multi_stage_watchdog_test;
   localparam int LW = 16;
   localparam int FW = 2;
   localparam int PL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [LW-1:0] cfg_len = '0;
   logic [1:0]    cfg_mode = '0;
   logic          poke = 1'b0;
   logic          irq, nmi, soft_reset;
   logic [1:0]    wdog_state;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      int         at;
      logic [1:0] st;
      logic       ex_srst;
      string      req;
   } exp_t;
   exp_t sb[$];

   multi_stage_watchdog #(.LEN_W(LW), .FRAC_W(FW), .PRESC_LOG2(PL)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
      .cfg_mode(cfg_mode), .poke(poke), .irq(irq), .nmi(nmi),
      .soft_reset(soft_reset), .wdog_state(wdog_state)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int period(input int len);
      return (len * (1 << FW) + 1) * (1 << PL);
   endfunction

   task automatic push(input int at, input logic [1:0] st, input logic sr, input string req);
      exp_t e;
      e.at = at; e.st = st; e.ex_srst = sr; e.req = req;
      sb.push_back(e);
   endtask

   task automatic compare(input string req, input logic [1:0] st, input logic sr);
      logic ei, en;
      ei = (st != 2'd0);
      en = st[1];
      checks++;
      if (wdog_state !== st || irq !== ei || nmi !== en || soft_reset !== sr) begin
         errors++;
         $display("FAIL %s cyc %0d: state/irq/nmi/srst actual %0d/%0b/%0b/%0b expected %0d/%0b/%0b/%0b",
                  req, cyc, wdog_state, irq, nmi, soft_reset, st, ei, en, sr);
      end
   endtask

   // monitor: pops expected items when their cycle comes up
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         if (e.at < cyc) begin
            checks++; errors++;
            $display("FAIL %s: item for cyc %0d missed, actual cyc %0d expected %0d", e.req, e.at, cyc, e.at);
         end else begin
            compare(e.req, e.st, e.ex_srst);
         end
      end
   end

   task automatic do_cfg(input int len, input logic [1:0] mode, input logic with_poke, output int e0);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_len = LW'(len); cfg_mode = mode; poke = with_poke;
      @(posedge clk); #1;
      e0 = cyc;
      cfg_we = 1'b0; poke = 1'b0;
   endtask

   task automatic do_poke(output int e0);
      @(posedge clk); #1;
      poke = 1'b1;
      @(posedge clk); #1;
      e0 = cyc;
      poke = 1'b0;
   endtask

   task automatic wait_to(input int c);
      while (cyc <= c) @(posedge clk);
      #1;
   endtask

   initial begin
      #(20 * 100000);
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cyc %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int e0, p;
      #5;
      compare("R1", 2'd0, 1'b0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      compare("R1", 2'd0, 1'b0);

      // R2 R3 R4 R8: full escalation with length 3
      do_cfg(3, 2'd3, 1'b0, e0);
      p = period(3);
      push(e0,         2'd0, 1'b0, "R9");
      push(e0+p-1,     2'd0, 1'b0, "R2");
      push(e0+p,       2'd1, 1'b0, "R2");
      push(e0+2*p-1,   2'd1, 1'b0, "R3");
      push(e0+2*p,     2'd2, 1'b0, "R3");
      push(e0+3*p-1,   2'd2, 1'b0, "R4");
      push(e0+3*p,     2'd3, 1'b1, "R8");
      push(e0+3*p+1,   2'd3, 1'b0, "R8");
      push(e0+3*p+120, 2'd3, 1'b0, "R8");
      wait_to(e0+3*p+121);

      // R5: poke returns to idle and restarts the period
      do_poke(e0);
      push(e0,       2'd0, 1'b0, "R5");
      push(e0+p-1,   2'd0, 1'b0, "R5");
      push(e0+p,     2'd1, 1'b0, "R5");
      wait_to(e0+p+1);

      // R7: mode 1 stops at the interrupt stage
      do_cfg(1, 2'd1, 1'b0, e0);
      p = period(1);
      push(e0+p-1,   2'd0, 1'b0, "R7");
      push(e0+p,     2'd1, 1'b0, "R7");
      push(e0+5*p,   2'd1, 1'b0, "R7");
      wait_to(e0+5*p+1);

      // R10 and R7: length 0, mode 2 stops at NMI
      do_cfg(0, 2'd2, 1'b0, e0);
      p = 1 << PL;
      push(e0+p-1,   2'd0, 1'b0, "R10");
      push(e0+p,     2'd1, 1'b0, "R10");
      push(e0+2*p,   2'd2, 1'b0, "R10");
      push(e0+30*p,  2'd2, 1'b0, "R7");
      wait_to(e0+30*p+1);

      // R6: mode 0 keeps everything quiet, even with a poke
      do_cfg(0, 2'd0, 1'b0, e0);
      push(e0,       2'd0, 1'b0, "R6");
      push(e0+100,   2'd0, 1'b0, "R6");
      wait_to(e0+101);
      do_poke(e0);
      push(e0+50,    2'd0, 1'b0, "R6");
      wait_to(e0+51);

      // R9: a write in the middle of a run, together with a poke, takes the new length
      do_cfg(0, 2'd3, 1'b0, e0);
      push(e0+(1<<PL), 2'd1, 1'b0, "R9");
      wait_to(e0+(1<<PL)+2);
      do_cfg(2, 2'd3, 1'b1, e0);
      p = period(2);
      push(e0,       2'd0, 1'b0, "R9");
      push(e0+p-1,   2'd0, 1'b0, "R9");
      push(e0+p,     2'd1, 1'b0, "R9");
      wait_to(e0+p+2);

      if (sb.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: leftover items actual %0d expected 0", sb.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule